// File: doc/BRIEF.md
# Dual-Channel Compare Waveform Generator

This block sits next to a shared timer counter and turns the running count into two reference waveforms. Each channel keeps its own compare value and an eight-bit slice of a sixteen-bit configuration word. On every clock it compares the counter with the channel's active compare value. It then registers a reference level that is chosen by a three-bit mode: hold, set on match, clear on match, toggle on match, forced low, forced high, or one of two complementary pulse-width modes. In the pulse-width modes the comparison sense depends on the count direction.

Compare writes can pass through a shadow register, so a new value takes effect only at the counter's update event and a PWM period is never torn. An external clear input can hold a channel's reference low until the next update event. Each channel also reports a registered match flag, whatever its mode.

Top module: `cmp_wave_gen`

## Requirements
- R1: After synchronous reset, both reference outputs and both match outputs are 0. The configuration word is 0, so every channel is in mode 0 with selection 0. Both active compare values are 0.
- R2: Channel n owns bits [8n+7:8n] of the configuration word, laid out as [1:0] selection, [2] fast enable, [3] preload enable, [6:4] mode and [7] clear enable. A configuration write is used from the following clock edge onward. The fast-enable bit is stored and changes no output.
- R3: In mode 0, the reference output keeps its level whatever the counter does.
- R4: In mode 1, the reference goes to 1 at an edge where the counter equals the active compare value. In mode 2, it goes to 0 at such an edge. At every other edge it keeps its level.
- R5: In mode 3, the reference inverts at every edge where the counter equals the active compare value.
- R6: Mode 4 drives the reference to 0 and mode 5 drives it to 1, independent of the counter.
- R7: In mode 6 the reference is 1 when counting up with counter < compare. When counting down, it is 1 when counter <= compare. It is 0 in all other cases.
- R8: Mode 7 gives the complement of the mode 6 level for the same counter, compare value and direction.
- R9: A compare write always loads the shadow. With preload enable clear, it also loads the active value, which is used from the next edge. With preload set, the active value changes only at an update event, which copies the shadow into it. A write in the same cycle as the update event is included in that copy.
- R10: With clear enable set, a clear input sampled high drives the reference to 0 and sets a hold. While the hold is set, the reference stays 0. The hold drops at an edge that samples the update event with the clear input low. When clear enable is 0, the clear input has no effect.
- R11: In every mode, the match output is 1 after an edge where the counter equalled the active compare value and the selection was 0. Otherwise it is 0.
- R12: A channel whose selection field is not 0 holds both its reference and its match output at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_i | input | CNT_W | Current timer counter value |
| cnt_down_i | input | 1 | 1 when the counter is counting down |
| upd_i | input | 1 | Update event strobe |
| ref_clr_i | input | 1 | External reference clear request |
| cfg_we_i | input | 1 | Configuration word write strobe |
| cfg_wdata_i | input | 8*NCH | Configuration word write data |
| cmp_we_i | input | NCH | Per-channel compare write strobe |
| cmp_wdata_i | input | CNT_W | Compare write data |
| ref_o | output | NCH | Registered reference level per channel |
| match_o | output | NCH | Registered compare-match flag per channel |

## Verification
On every cycle, the assertions check the properties that need no history. Forced-low mode always yields 0. Frozen mode leaves the level unchanged. A sampled clear always drives the reference low. A non-zero selection silences both outputs. Every equality between the counter and the active value raises the match flag. A direct compare write shows up in the active value one edge later, and a preloaded write without an update event leaves it untouched. Only the bench's scenarios can show the full waveforms. These are the PWM comparison sense in each direction at compare values 0, 100 and 255, and the accumulated toggles and set/clear sequences across long sweeps. They also include the hold lasting until the update event and the shadow-to-active transfer timing.

// File: rtl/cmpw_pkg.sv
package cmpw_pkg;

  // Reference-generation modes; the encoding is software visible.
  typedef enum logic [2:0] {
    M_HOLD  = 3'd0,
    M_SET   = 3'd1,
    M_CLR   = 3'd2,
    M_FLIP  = 3'd3,
    M_LOW   = 3'd4,
    M_HIGH  = 3'd5,
    M_PWM_A = 3'd6,
    M_PWM_B = 3'd7
  } cmpw_mode_e;

  // One channel's byte of the configuration word, MSB first.
  typedef struct packed {
    logic       clr_en;
    cmpw_mode_e mode;
    logic       pre_en;
    logic       fast_en;
    logic [1:0] sel;
  } cmpw_chcfg_t;

  localparam int CHCFG_W = $bits(cmpw_chcfg_t);

endpackage

// File: rtl/cmpw_cfg_reg.sv
module cmpw_cfg_reg
  import cmpw_pkg::*;
#(
  parameter int NCH = 2,
  localparam int CFG_W = NCH * CHCFG_W
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          we_i,
  input  logic [CFG_W-1:0]              wdata_i,
  output cmpw_chcfg_t [NCH-1:0]         ch_cfg_o
);

  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (we_i) begin
      cfg_q <= wdata_i;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_slice
    assign ch_cfg_o[g] = cmpw_chcfg_t'(cfg_q[g*CHCFG_W +: CHCFG_W]);
  end

  // R2: a write lands in the stored word one edge later
  a_r2_cfg_write: assert property (@(posedge clk) disable iff (rst)
    we_i |=> (ch_cfg_o == $past(wdata_i)));

endmodule

// File: rtl/cmpw_cmp_reg.sv
module cmpw_cmp_reg #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             pre_en_i,
  input  logic             upd_i,
  output logic [CNT_W-1:0] act_o
);

  logic [CNT_W-1:0] shadow_q;
  logic [CNT_W-1:0] shadow_d;
  logic [CNT_W-1:0] act_q;
  logic             act_load;

  always_comb begin
    shadow_d = we_i ? wdata_i : shadow_q;
    act_load = upd_i || (we_i && !pre_en_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      act_q    <= '0;
    end else begin
      shadow_q <= shadow_d;
      if (act_load) begin
        act_q <= shadow_d;
      end
    end
  end

  assign act_o = act_q;

  // R9: direct write reaches the active value at the next edge
  a_r9_direct: assert property (@(posedge clk) disable iff (rst)
    (we_i && !pre_en_i) |=> (act_o == $past(wdata_i)));

  // R9: preloaded write without update leaves the active value alone
  a_r9_shadowed: assert property (@(posedge clk) disable iff (rst)
    (we_i && pre_en_i && !upd_i) |=> (act_o == $past(act_o)));

endmodule

// File: rtl/cmpw_ref_gen.sv
module cmpw_ref_gen
  import cmpw_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  cmpw_chcfg_t      cfg_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cnt_down_i,
  input  logic             upd_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] act_i,
  output logic             ref_o,
  output logic             match_o
);

  logic ref_q;
  logic match_q;
  logic hold_q;
  logic eq;
  logic pwm_lvl;
  logic mode_lvl;
  logic clr_now;
  logic chan_off;
  logic ref_d;
  logic hold_d;

  always_comb begin
    eq       = (cnt_i == act_i);
    // up: high below compare; down: high at or below compare
    pwm_lvl  = cnt_down_i ? (cnt_i <= act_i) : (cnt_i < act_i);
    unique case (cfg_i.mode)
      M_HOLD:  mode_lvl = ref_q;
      M_SET:   mode_lvl = eq ? 1'b1 : ref_q;
      M_CLR:   mode_lvl = eq ? 1'b0 : ref_q;
      M_FLIP:  mode_lvl = eq ? !ref_q : ref_q;
      M_LOW:   mode_lvl = 1'b0;
      M_HIGH:  mode_lvl = 1'b1;
      M_PWM_A: mode_lvl = pwm_lvl;
      M_PWM_B: mode_lvl = !pwm_lvl;
      default: mode_lvl = ref_q;
    endcase
    chan_off = (cfg_i.sel != 2'd0);
    clr_now  = cfg_i.clr_en && clr_i;
    ref_d    = (chan_off || clr_now || hold_q) ? 1'b0 : mode_lvl;
    hold_d   = clr_now || (hold_q && !upd_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q   <= 1'b0;
      match_q <= 1'b0;
      hold_q  <= 1'b0;
    end else begin
      ref_q   <= ref_d;
      match_q <= eq && !chan_off;
      hold_q  <= hold_d;
    end
  end

  assign ref_o   = ref_q;
  assign match_o = match_q;

  // R6: forced-low mode always yields a low reference
  a_r6_force_low: assert property (@(posedge clk) disable iff (rst)
    (cfg_i.mode == M_LOW) |=> !ref_o);

  // R3: frozen mode keeps the level when nothing overrides it
  a_r3_frozen_keeps: assert property (@(posedge clk) disable iff (rst)
    (cfg_i.mode == M_HOLD && cfg_i.sel == 2'd0 && !clr_now && !hold_q)
    |=> (ref_o == $past(ref_o)));

  // R10: a sampled clear request drives the reference low
  a_r10_clear_low: assert property (@(posedge clk) disable iff (rst)
    (cfg_i.clr_en && clr_i) |=> !ref_o);

  // R11: equality raises the match flag for an output channel
  a_r11_match: assert property (@(posedge clk) disable iff (rst)
    (cfg_i.sel == 2'd0 && cnt_i == act_i) |=> match_o);

  // R12: a non-output selection silences the channel
  a_r12_sel_off: assert property (@(posedge clk) disable iff (rst)
    (cfg_i.sel != 2'd0) |=> (!ref_o && !match_o));

endmodule

// File: rtl/cmp_wave_gen.sv
module cmp_wave_gen
  import cmpw_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int NCH   = 2,
  localparam int CFG_W = NCH * CHCFG_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cnt_down_i,
  input  logic             upd_i,
  input  logic             ref_clr_i,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic [NCH-1:0]   cmp_we_i,
  input  logic [CNT_W-1:0] cmp_wdata_i,
  output logic [NCH-1:0]   ref_o,
  output logic [NCH-1:0]   match_o
);

  cmpw_chcfg_t [NCH-1:0] ch_cfg;

  cmpw_cfg_reg #(.NCH(NCH)) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .we_i     (cfg_we_i),
    .wdata_i  (cfg_wdata_i),
    .ch_cfg_o (ch_cfg)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [CNT_W-1:0] act;

    cmpw_cmp_reg #(.CNT_W(CNT_W)) u_cmp (
      .clk      (clk),
      .rst      (rst),
      .we_i     (cmp_we_i[g]),
      .wdata_i  (cmp_wdata_i),
      .pre_en_i (ch_cfg[g].pre_en),
      .upd_i    (upd_i),
      .act_o    (act)
    );

    cmpw_ref_gen #(.CNT_W(CNT_W)) u_ref (
      .clk        (clk),
      .rst        (rst),
      .cfg_i      (ch_cfg[g]),
      .cnt_i      (cnt_i),
      .cnt_down_i (cnt_down_i),
      .upd_i      (upd_i),
      .clr_i      (ref_clr_i),
      .act_i      (act),
      .ref_o      (ref_o[g]),
      .match_o    (match_o[g])
    );
  end

endmodule

// File: tb/cmp_wave_gen_tb.sv
`timescale 1ns/1ps
module cmp_wave_gen_tb;

  localparam int CW  = 8;
  localparam int NC  = 2;
  localparam int FW  = NC * 8;
  localparam int MAXV = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [CW-1:0] cnt = '0;
  logic          dn = 1'b0;
  logic          upd = 1'b0;
  logic          clr = 1'b0;
  logic          cfg_we = 1'b0;
  logic [FW-1:0] cfg_wd = '0;
  logic [NC-1:0] cmp_we = '0;
  logic [CW-1:0] cmp_wd = '0;
  logic [NC-1:0] ref_o;
  logic [NC-1:0] match_o;

  int n_chk = 0;
  int n_bad = 0;

  // bench model state
  logic [FW-1:0] m_cfg = '0;
  int            m_act [NC];
  int            m_sh  [NC];
  logic          m_ref [NC];
  logic          m_mat [NC];
  logic          m_hold[NC];

  always #2.5 clk = ~clk;

  cmp_wave_gen #(.CNT_W(CW), .NCH(NC)) u_dut (
    .clk(clk), .rst(rst), .cnt_i(cnt), .cnt_down_i(dn), .upd_i(upd),
    .ref_clr_i(clr), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wd),
    .cmp_we_i(cmp_we), .cmp_wdata_i(cmp_wd), .ref_o(ref_o), .match_o(match_o)
  );

  function automatic logic [7:0] chb(input logic ce, input int md,
                                     input logic pe, input logic fe, input int sl);
    return {ce, 3'(md), pe, fe, 2'(sl)};
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  // one clock: model the edge from the requirements, then compare
  task automatic cyc();
    int    nact[NC];
    int    nsh[NC];
    logic  nref[NC];
    logic  nmat[NC];
    logic  nhold[NC];
    string tg[NC];
    for (int c = 0; c < NC; c++) begin
      int   sl = int'(m_cfg[c*8 +: 2]);
      logic pe = m_cfg[c*8+3];
      int   md = int'(m_cfg[c*8+4 +: 3]);
      logic ce = m_cfg[c*8+7];
      int   cv = int'(cnt);
      logic eq = (cv == m_act[c]);
      logic pw = dn ? (cv <= m_act[c]) : (cv < m_act[c]);
      logic lv;
      logic cn = ce && clr;
      case (md)
        0: begin lv = m_ref[c];                 tg[c] = "R3"; end
        1: begin lv = eq ? 1'b1 : m_ref[c];     tg[c] = "R4"; end
        2: begin lv = eq ? 1'b0 : m_ref[c];     tg[c] = "R4"; end
        3: begin lv = eq ? !m_ref[c] : m_ref[c]; tg[c] = "R5"; end
        4: begin lv = 1'b0;                     tg[c] = "R6"; end
        5: begin lv = 1'b1;                     tg[c] = "R6"; end
        6: begin lv = pw;                       tg[c] = "R7"; end
        default: begin lv = !pw;                tg[c] = "R8"; end
      endcase
      if (cn || m_hold[c]) tg[c] = "R10";
      if (sl != 0) tg[c] = "R12";
      nref[c]  = (sl != 0 || cn || m_hold[c]) ? 1'b0 : lv;
      nmat[c]  = (sl == 0) && eq;
      nhold[c] = cn || (m_hold[c] && !upd);
      nsh[c]   = cmp_we[c] ? int'(cmp_wd) : m_sh[c];
      nact[c]  = (upd || (cmp_we[c] && !pe)) ? nsh[c] : m_act[c];
    end
    if (cfg_we) m_cfg = cfg_wd;
    @(posedge clk);
    #1;
    for (int c = 0; c < NC; c++) begin
      m_ref[c] = nref[c]; m_mat[c] = nmat[c]; m_hold[c] = nhold[c];
      m_sh[c] = nsh[c]; m_act[c] = nact[c];
    end
    upd = 1'b0; clr = 1'b0; cfg_we = 1'b0; cmp_we = '0;
    for (int c = 0; c < NC; c++) begin
      chk(tg[c], ref_o[c], m_ref[c]);
      chk((m_cfg[c*8 +: 2] != 2'd0) ? "R12" : "R11", match_o[c], m_mat[c]);
    end
  endtask

  task automatic wr_cfg(input logic [FW-1:0] v);
    cfg_we = 1'b1; cfg_wd = v; cyc();
  endtask

  task automatic wr_cmp(input int c, input int v);
    cmp_we = '0; cmp_we[c] = 1'b1; cmp_wd = CW'(v); cyc();
  endtask

  initial begin
    #(200000 * 5.0);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < NC; c++) begin
      m_act[c] = 0; m_sh[c] = 0; m_ref[c] = 0; m_mat[c] = 0; m_hold[c] = 0;
    end
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1: reset state
    chk("R1", ref_o[0], 1'b0); chk("R1", ref_o[1], 1'b0);
    chk("R1", match_o[0], 1'b0); chk("R1", match_o[1], 1'b0);
    cnt = '0; cyc();
    // R1: compare values 0 and selection 0 after reset -> match at count 0
    chk("R1", match_o[0], 1'b1); chk("R1", match_o[1], 1'b1);

    // mode sweep, both directions, several compare values
    for (int p = 0; p < 2; p++) begin
      for (int m = 0; m < 8; m++) begin
        for (int d = 0; d < 2; d++) begin
          wr_cfg({chb(0, m, 0, 1'(p), 0), chb(0, m, 0, 0, 0)});
          wr_cmp(0, 100);
          wr_cmp(1, (p == 1) ? MAXV : 0);
          dn = 1'(d);
          for (int k = 0; k <= MAXV; k++) begin
            cnt = CW'(d ? (MAXV - k) : k);
            cyc();
          end
        end
      end
    end

    // R2: channel bytes are independent; fast enable changes nothing
    wr_cfg({chb(0, 5, 0, 1, 0), chb(0, 4, 0, 1, 0)});
    cyc();
    chk("R2", ref_o[0], 1'b0); chk("R2", ref_o[1], 1'b1);

    // R9: preloaded compare write waits for the update event
    dn = 1'b0; cnt = 8'd0;
    wr_cfg({chb(0, 0, 0, 0, 0), chb(0, 6, 1, 0, 0)});
    wr_cmp(0, 50);
    cnt = 8'd60; cyc(); chk("R9", ref_o[0], 1'b1);
    cnt = 8'd50; cyc(); chk("R9", match_o[0], 1'b0);
    upd = 1'b1; cyc();
    cnt = 8'd60; cyc(); chk("R9", ref_o[0], 1'b0);
    cnt = 8'd50; cyc(); chk("R9", match_o[0], 1'b1);
    // R9: without preload the write is used from the next edge
    wr_cfg({chb(0, 0, 0, 0, 0), chb(0, 6, 0, 0, 0)});
    wr_cmp(0, 200);
    cnt = 8'd150; cyc(); chk("R9", ref_o[0], 1'b1);

    // R10: clear hold until update; ignored without clear enable
    wr_cfg({chb(0, 5, 0, 0, 0), chb(1, 5, 0, 0, 0)});
    cyc(); chk("R10", ref_o[0], 1'b1);
    clr = 1'b1; cyc();
    chk("R10", ref_o[0], 1'b0); chk("R10", ref_o[1], 1'b1);
    repeat (3) cyc();
    chk("R10", ref_o[0], 1'b0);
    upd = 1'b1; cyc(); chk("R10", ref_o[0], 1'b0);
    cyc(); chk("R10", ref_o[0], 1'b1);

    // R12: non-zero selection silences a channel
    wr_cfg({chb(0, 5, 0, 0, 0), chb(0, 5, 0, 0, 2)});
    wr_cmp(0, 7);
    wr_cmp(1, 7);
    cnt = 8'd7; cyc();
    chk("R12", ref_o[0], 1'b0); chk("R12", match_o[0], 1'b0);
    chk("R12", ref_o[1], 1'b1); chk("R11", match_o[1], 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule